// File: doc/BRIEF.md
# Inter-processor interrupt source tracker

This block keeps track of software-generated inter-processor interrupts for a small cluster of processors. For every target processor and every one of its software interrupt numbers it stores a source mask. Bit n of the mask is set while processor n has an undelivered request for that interrupt. An interrupt counts as pending on a target for as long as its mask is non-zero. It leaves the pending state only after every requesting source has been handed to the delivery logic.

Three agents change the masks. A dispatcher posts a request from one source to any set of targets. A register port reads and edits the masks through two 32-bit windows. One window sets bits and the other clears them, and each word covers a group of four consecutive interrupt numbers. A delivery port offers the lowest pending source of one selected interrupt, removes that source only when the offer is accepted, and reports completion once the interrupt has no sources left.

Top module: `ipi_tracker`

## Requirements
- R1: After a clock edge with `rst_n` low, every source mask is zero, `pending` is all zero and `reg_rdata` reads zero.
- R2: `reg_rdata` byte k always shows the mask of interrupt `reg_word*4 + k` on processor `reg_cpu`. Which window `reg_clr` selects does not change what is read.
- R3: A write with `reg_clr`=0 ORs byte k of `reg_wdata` into the mask of interrupt `reg_word*4 + k` of processor `reg_cpu` at the clock edge.
- R4: A write with `reg_clr`=1 clears, in those same masks, every bit that is 1 in the matching byte of `reg_wdata`.
- R5: `reg_changed` is high, in the same cycle as the write, exactly when a window write would alter at least one mask bit. It is low for reads and for writes that change nothing.
- R6: A cycle with `disp_valid` high sets bit `disp_src` in the mask of interrupt `disp_sgi` on every processor whose bit is 1 in `disp_targets`.
- R7: All updates in one cycle merge into a single result. When a set (from the window or the dispatcher) and a clear (from the window or from delivery) hit the same bit in the same cycle, the bit ends up set.
- R8: While `dlv_req` is high and the mask of (`dlv_cpu`, `dlv_sgi`) is non-zero, `offer_valid` is high and `offer_src` is its lowest set bit. That bit is cleared at the clock edge only if `offer_accept` is high.
- R9: In the cycle after an accepted offer, `dlv_done` is high, with `done_cpu`/`done_sgi` naming the interrupt, exactly when that mask is then zero.
- R10: `pending[c*16 + s]` equals the OR of the mask of interrupt s on processor c, with no extra register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_clr | input | 1 | Window select: 0 = set window, 1 = clear window |
| reg_cpu | input | 3 | Processor whose masks are accessed |
| reg_word | input | 2 | Word index: a group of four interrupt numbers |
| reg_wdata | input | 32 | Write data, one mask byte per interrupt |
| reg_rdata | output | 32 | Current masks of the addressed group |
| reg_changed | output | 1 | Current write alters at least one bit |
| disp_valid | input | 1 | Dispatcher request strobe |
| disp_src | input | 3 | Requesting processor |
| disp_sgi | input | 4 | Interrupt number requested |
| disp_targets | input | 8 | Target processors, one bit each |
| dlv_req | input | 1 | Delivery logic asks for a source |
| dlv_cpu | input | 3 | Target processor being delivered to |
| dlv_sgi | input | 4 | Interrupt being delivered |
| offer_valid | output | 1 | A source is offered |
| offer_src | output | 3 | Offered source processor |
| offer_accept | input | 1 | Offer taken by a delivery slot |
| dlv_done | output | 1 | Interrupt fully delivered |
| done_cpu | output | 3 | Processor of the completed interrupt |
| done_sgi | output | 4 | Number of the completed interrupt |
| pending | output | 128 | Per-processor, per-interrupt pending flags |

## Verification
On every cycle, the assertions check these rules: the change flag appears only on writes; an offer appears only for a requested, pending interrupt; completion follows an accepted offer and leaves the interrupt not pending; the read window agrees with the pending flags; and reset clears all pending state. Other behaviour shows only in the bench's scenarios against its reference model. These cases include the exact OR and AND-NOT effects of the two windows, fan-out of a dispatch to several targets, and set winning over a clear on the same bit in one cycle. They also include the offer holding while it is not accepted, and the choice of the lowest source.

// File: rtl/ipi_pkg.sv
// Shared constants for the inter-processor interrupt source tracker.
// Assumes a byte per source mask, so a 32-bit word carries four masks.
package ipi_pkg;
    localparam int unsigned IPI_GROUP = 4;   // interrupt numbers per register word
    typedef enum logic { WIN_SET = 1'b0, WIN_CLR = 1'b1 } win_e;
endpackage

// File: rtl/ipi_src_cell.sv
// One source mask: holds the requesting processors of one interrupt on one
// target. Applies clear then set in the same edge so a set always wins.
// Assumes set/clear vectors are already merged from all agents.
module ipi_src_cell #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] mask_o,
    output logic         pend_o
);
    logic [W-1:0] mask_q;

    // Mask register: sync reset, clear-then-set update.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= (mask_q & ~clr_i) | set_i;
    end

    assign mask_o = mask_q;
    assign pend_o = |mask_q;
endmodule

// File: rtl/ipi_win_port.sv
// Register window: reads a group of masks of one processor and expands a
// set- or clear-window write into per-interrupt set/clear vectors. Also
// flags whether the write alters any bit. Assumes NCPU-bit bytes in the word.
module ipi_win_port #(
    parameter int unsigned NCPU = 8,
    parameter int unsigned NSGI = 16,
    parameter int unsigned GRP  = 4,
    localparam int unsigned DW  = GRP * NCPU,
    localparam int unsigned WW  = (NSGI / GRP > 1) ? $clog2(NSGI / GRP) : 1
) (
    input  logic                      valid_i,
    input  logic                      write_i,
    input  logic                      clr_i,
    input  logic [WW-1:0]             word_i,
    input  logic [DW-1:0]             wdata_i,
    input  logic [NSGI-1:0][NCPU-1:0] masks_i,
    output logic [DW-1:0]             rdata_o,
    output logic                      changed_o,
    output logic [NSGI-1:0][NCPU-1:0] set_o,
    output logic [NSGI-1:0][NCPU-1:0] clr_o
);
    logic                 wr;
    logic [NSGI-1:0]      alter;

    assign wr = valid_i && write_i;

    // Read mux: one byte per interrupt of the addressed group.
    always_comb begin
        rdata_o = '0;
        for (int g = 0; g < int'(GRP); g++)
            rdata_o[g*NCPU +: NCPU] = masks_i[int'(word_i)*GRP + g];
    end

    for (genvar s = 0; s < NSGI; s++) begin : g_sgi
        localparam int unsigned WIDX = s / GRP;
        localparam int unsigned BIDX = s % GRP;
        logic hit;
        logic [NCPU-1:0] byte_v;
        assign hit    = wr && (word_i == WW'(WIDX));
        assign byte_v = wdata_i[BIDX*NCPU +: NCPU];
        assign set_o[s] = (hit && !clr_i) ? byte_v : '0;
        assign clr_o[s] = (hit &&  clr_i) ? byte_v : '0;
        assign alter[s] = |(set_o[s] & ~masks_i[s]) || |(clr_o[s] & masks_i[s]);
    end

    assign changed_o = |alter;
endmodule

// File: rtl/ipi_drain.sv
// Delivery drain: offers the lowest set source of the selected mask and
// produces the clear vector for it when the offer is accepted.
module ipi_drain #(
    parameter int unsigned NCPU = 8,
    localparam int unsigned CW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic            req_i,
    input  logic            accept_i,
    input  logic [NCPU-1:0] mask_i,
    output logic            offer_o,
    output logic [CW-1:0]   src_o,
    output logic            take_o,
    output logic [NCPU-1:0] clr_o
);
    logic [NCPU-1:0] pick;

    // Lowest-set-bit picker.
    always_comb begin
        pick  = '0;
        src_o = '0;
        for (int i = int'(NCPU) - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
                src_o   = CW'(i);
            end
        end
    end

    assign offer_o = req_i && (|mask_i);
    assign take_o  = offer_o && accept_i;
    assign clr_o   = take_o ? pick : '0;
endmodule

// File: rtl/ipi_tracker.sv
// Inter-processor interrupt source tracker top. Holds an NCPU-bit source
// mask per (target processor, interrupt), merges dispatcher, register window
// and delivery updates each cycle, and signals completion one cycle after
// the last source of an interrupt is taken. Assumes a single register access
// and a single delivery request per cycle.
module ipi_tracker #(
    parameter int unsigned NCPU = 8,
    parameter int unsigned NSGI = 16,
    localparam int unsigned GRP = ipi_pkg::IPI_GROUP,
    localparam int unsigned DW  = GRP * NCPU,
    localparam int unsigned CW  = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int unsigned SW  = (NSGI > 1) ? $clog2(NSGI) : 1,
    localparam int unsigned WW  = (NSGI / GRP > 1) ? $clog2(NSGI / GRP) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_valid,
    input  logic                 reg_write,
    input  logic                 reg_clr,
    input  logic [CW-1:0]        reg_cpu,
    input  logic [WW-1:0]        reg_word,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    output logic                 reg_changed,
    input  logic                 disp_valid,
    input  logic [CW-1:0]        disp_src,
    input  logic [SW-1:0]        disp_sgi,
    input  logic [NCPU-1:0]      disp_targets,
    input  logic                 dlv_req,
    input  logic [CW-1:0]        dlv_cpu,
    input  logic [SW-1:0]        dlv_sgi,
    output logic                 offer_valid,
    output logic [CW-1:0]        offer_src,
    input  logic                 offer_accept,
    output logic                 dlv_done,
    output logic [CW-1:0]        done_cpu,
    output logic [SW-1:0]        done_sgi,
    output logic [NCPU*NSGI-1:0] pending
);
    logic [NSGI-1:0][NCPU-1:0] mask_a [NCPU];
    logic [NSGI-1:0][NCPU-1:0] win_set, win_clr;
    logic [NCPU-1:0]           drain_clr;
    logic [NCPU-1:0]           disp_oh;
    logic                      take;
    logic                      take_q;
    logic [CW-1:0]             cpu_q;
    logic [SW-1:0]             sgi_q;

    ipi_win_port #(.NCPU(NCPU), .NSGI(NSGI), .GRP(GRP)) win_i (
        .valid_i(reg_valid), .write_i(reg_write), .clr_i(reg_clr),
        .word_i(reg_word), .wdata_i(reg_wdata), .masks_i(mask_a[reg_cpu]),
        .rdata_o(reg_rdata), .changed_o(reg_changed),
        .set_o(win_set), .clr_o(win_clr)
    );

    ipi_drain #(.NCPU(NCPU)) drain_i (
        .req_i(dlv_req), .accept_i(offer_accept),
        .mask_i(mask_a[dlv_cpu][dlv_sgi]),
        .offer_o(offer_valid), .src_o(offer_src),
        .take_o(take), .clr_o(drain_clr)
    );

    // One-hot of the dispatching source.
    always_comb begin
        disp_oh = '0;
        disp_oh[disp_src] = 1'b1;
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        for (genvar s = 0; s < NSGI; s++) begin : g_sgi
            logic [NCPU-1:0] cset, cclr;
            logic            reg_hit, dlv_hit, dsp_hit;
            assign reg_hit = (reg_cpu == CW'(c));
            assign dlv_hit = (dlv_cpu == CW'(c)) && (dlv_sgi == SW'(s));
            assign dsp_hit = disp_valid && disp_targets[c] && (disp_sgi == SW'(s));
            assign cset = (reg_hit ? win_set[s] : '0) | (dsp_hit ? disp_oh : '0);
            assign cclr = (reg_hit ? win_clr[s] : '0) | (dlv_hit ? drain_clr : '0);
            ipi_src_cell #(.W(NCPU)) cell_i (
                .clk(clk), .rst_n(rst_n), .set_i(cset), .clr_i(cclr),
                .mask_o(mask_a[c][s]), .pend_o(pending[c*NSGI + s])
            );
        end
    end

    // Remember the interrupt whose offer was taken, for completion next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            cpu_q  <= '0;
            sgi_q  <= '0;
        end else begin
            take_q <= take;
            cpu_q  <= dlv_cpu;
            sgi_q  <= dlv_sgi;
        end
    end

    assign done_cpu = cpu_q;
    assign done_sgi = sgi_q;
    assign dlv_done = take_q && !pending[int'(cpu_q)*NSGI + int'(sgi_q)];
endmodule

// File: rtl/ipi_tracker_chk.sv
// Checker for ipi_tracker, attached by bind. Watches ports only.
module ipi_tracker_chk #(
    parameter int unsigned NCPU = 8,
    parameter int unsigned NSGI = 16,
    localparam int unsigned GRP = ipi_pkg::IPI_GROUP,
    localparam int unsigned DW  = GRP * NCPU,
    localparam int unsigned CW  = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int unsigned SW  = (NSGI > 1) ? $clog2(NSGI) : 1,
    localparam int unsigned WW  = (NSGI / GRP > 1) ? $clog2(NSGI / GRP) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_valid,
    input logic                 reg_write,
    input logic [CW-1:0]        reg_cpu,
    input logic [WW-1:0]        reg_word,
    input logic [DW-1:0]        reg_rdata,
    input logic                 reg_changed,
    input logic                 dlv_req,
    input logic [CW-1:0]        dlv_cpu,
    input logic [SW-1:0]        dlv_sgi,
    input logic                 offer_valid,
    input logic                 offer_accept,
    input logic                 dlv_done,
    input logic [CW-1:0]        done_cpu,
    input logic [SW-1:0]        done_sgi,
    input logic [NCPU*NSGI-1:0] pending
);
    logic pend_dlv, pend_done, pend_rd;

    // Pending flags of the slots each port currently addresses.
    always_comb begin
        pend_dlv  = pending[int'(dlv_cpu)*NSGI + int'(dlv_sgi)];
        pend_done = pending[int'(done_cpu)*NSGI + int'(done_sgi)];
        pend_rd   = pending[int'(reg_cpu)*NSGI + int'(reg_word)*GRP];
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (pending == '0));

    // R5
    change_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_changed |-> (reg_valid && reg_write));

    // R8
    offer_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> (dlv_req && pend_dlv));

    // R9
    done_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_done |-> ($past(offer_valid && offer_accept) && !pend_done));

    // R10
    read_matches_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write) |-> ((|reg_rdata[NCPU-1:0]) == pend_rd));
endmodule

bind ipi_tracker ipi_tracker_chk #(.NCPU(NCPU), .NSGI(NSGI)) chk_i (.*);

// File: tb/ipi_tracker_tb_top.sv
// Bench for ipi_tracker: directed corner cases, then seeded random traffic,
// all compared against a bench-side model of the source masks.
module ipi_tracker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 8;
    localparam int NSGI = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 0, reg_write = 0, reg_clr = 0;
    logic [2:0]  reg_cpu = 0;
    logic [1:0]  reg_word = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        reg_changed;
    logic        disp_valid = 0;
    logic [2:0]  disp_src = 0;
    logic [3:0]  disp_sgi = 0;
    logic [7:0]  disp_targets = 0;
    logic        dlv_req = 0;
    logic [2:0]  dlv_cpu = 0;
    logic [3:0]  dlv_sgi = 0;
    logic        offer_valid;
    logic [2:0]  offer_src;
    logic        offer_accept = 0;
    logic        dlv_done;
    logic [2:0]  done_cpu;
    logic [3:0]  done_sgi;
    logic [127:0] pending;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] m [NCPU][NSGI];
    bit         exp_done = 0;
    logic [2:0] exp_dcpu = 0;
    logic [3:0] exp_dsgi = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_tracker dut_i (.*);

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_word(input int c, input int w);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++) r[k*8 +: 8] = m[c][w*4 + k];
        return r;
    endfunction

    function automatic logic [127:0] model_pend();
        logic [127:0] p = '0;
        for (int c = 0; c < NCPU; c++)
            for (int s = 0; s < NSGI; s++) p[c*NSGI + s] = |m[c][s];
        return p;
    endfunction

    function automatic bit model_changed();
        bit ch = 0;
        if (reg_valid && reg_write)
            for (int k = 0; k < 4; k++) begin
                logic [7:0] b = reg_wdata[k*8 +: 8];
                logic [7:0] cur = m[reg_cpu][reg_word*4 + k];
                if (!reg_clr && ((b & ~cur) != 0)) ch = 1;
                if (reg_clr && ((b & cur) != 0)) ch = 1;
            end
        return ch;
    endfunction

    function automatic int lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 0;
    endfunction

    // Check outputs between edges, then advance one clock and update the model.
    task automatic cycle();
        logic [7:0] sel;
        bit take;
        #1;
        chk("R2 read window", reg_rdata, model_word(reg_cpu, reg_word));
        chk("R5 change flag", reg_changed, model_changed());
        chk("R10 pending flags", pending, model_pend());
        chk("R9 done flag", dlv_done, exp_done);
        if (exp_done) chk("R9 done id", {done_cpu, done_sgi}, {exp_dcpu, exp_dsgi});
        sel = m[dlv_cpu][dlv_sgi];
        chk("R8 offer valid", offer_valid, dlv_req && (sel != 0));
        if (dlv_req && sel != 0) chk("R8 offer src", offer_src, lowest(sel));
        take = dlv_req && (sel != 0) && offer_accept;
        @(posedge clk);
        for (int c = 0; c < NCPU; c++)
            for (int s = 0; s < NSGI; s++) begin
                logic [7:0] st = 0, cl = 0;
                if (reg_valid && reg_write && reg_cpu == c && reg_word == s/4) begin
                    if (reg_clr) cl |= reg_wdata[(s%4)*8 +: 8];
                    else         st |= reg_wdata[(s%4)*8 +: 8];
                end
                if (disp_valid && disp_targets[c] && disp_sgi == s) st[disp_src] = 1;
                if (take && dlv_cpu == c && dlv_sgi == s) cl[lowest(sel)] = 1;
                m[c][s] = (m[c][s] & ~cl) | st;
            end
        exp_done = take && (m[dlv_cpu][dlv_sgi] == 0);
        exp_dcpu = dlv_cpu;
        exp_dsgi = dlv_sgi;
        @(negedge clk);
    endtask

    task automatic idle();
        reg_valid = 0; reg_write = 0; reg_clr = 0;
        disp_valid = 0; dlv_req = 0; offer_accept = 0;
    endtask

    task automatic rd(input int c, input int w, input logic [31:0] e, input string tag);
        idle();
        reg_valid = 1; reg_cpu = 3'(c); reg_word = 2'(w);
        #1 chk(tag, reg_rdata, e);
        cycle();
    endtask

    task automatic wr(input int c, input int w, input bit clr, input logic [31:0] d);
        idle();
        reg_valid = 1; reg_write = 1; reg_clr = clr;
        reg_cpu = 3'(c); reg_word = 2'(w); reg_wdata = d;
        cycle();
    endtask

    task automatic dispatch(input int src, input int sgi, input logic [7:0] tg);
        idle();
        disp_valid = 1; disp_src = 3'(src); disp_sgi = 4'(sgi); disp_targets = tg;
        cycle();
    endtask

    task automatic deliver(input int c, input int s, input bit acc);
        idle();
        dlv_req = 1; dlv_cpu = 3'(c); dlv_sgi = 4'(s); offer_accept = acc;
        cycle();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1a2b3c4d));
        for (int c = 0; c < NCPU; c++)
            for (int s = 0; s < NSGI; s++) m[c][s] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        #1 chk("R1 pending after reset", pending, '0);
        chk("R1 rdata after reset", reg_rdata, '0);
        cycle();

        // R6: fan-out of one dispatch to processors 0 and 2
        dispatch(5, 1, 8'h05);
        rd(0, 0, 32'h0000_2000, "R6 target cpu0");
        rd(2, 0, 32'h0000_2000, "R6 target cpu2");
        rd(1, 0, 32'h0000_0000, "R6 untargeted cpu1");

        // R3: set window ORs; repeated set changes nothing
        wr(1, 3, 0, 32'h8100_0300);
        rd(1, 3, 32'h8100_0300, "R3 set write");
        wr(1, 3, 0, 32'h0000_0100);
        rd(1, 3, 32'h8100_0300, "R3 repeated set");
        // R2: clear window reads the same masks
        idle(); reg_valid = 1; reg_clr = 1; reg_cpu = 1; reg_word = 3;
        #1 chk("R2 clear-window read", reg_rdata, 32'h8100_0300);
        cycle();

        // R4: clear window ANDs with inverted byte
        wr(1, 3, 1, 32'h0100_0100);
        rd(1, 3, 32'h8000_0200, "R4 clear write");

        // R7: clear and dispatch on the same bit in one cycle, set wins
        idle();
        reg_valid = 1; reg_write = 1; reg_clr = 1; reg_cpu = 2; reg_word = 0;
        reg_wdata = 32'hFFFF_FFFF;
        disp_valid = 1; disp_src = 3; disp_sgi = 0; disp_targets = 8'h04;
        cycle();
        rd(2, 0, 32'h0000_0008, "R7 set beats clear");

        // R7: delivery clear and window set of the same bit, set wins
        idle();
        dlv_req = 1; dlv_cpu = 2; dlv_sgi = 0; offer_accept = 1;
        reg_valid = 1; reg_write = 1; reg_clr = 0; reg_cpu = 2; reg_word = 0;
        reg_wdata = 32'h0000_0008;
        cycle();
        rd(2, 0, 32'h0000_0008, "R7 set beats delivery");

        // R8/R9: deliver the single source, completion follows
        deliver(2, 0, 1);
        rd(2, 0, 32'h0000_0000, "R9 mask empty after last take");

        // R8: an unaccepted offer keeps its bit; two sources need two takes
        wr(4, 1, 0, 32'h0000_0090);   // cpu4 sgi4 sources 4 and 7
        deliver(4, 4, 0);
        rd(4, 1, 32'h0000_0090, "R8 no accept keeps mask");
        deliver(4, 4, 1);
        rd(4, 1, 32'h0000_0080, "R8 lowest source removed");
        deliver(4, 4, 1);
        deliver(1, 15, 1);
        deliver(1, 13, 1);
        rd(1, 3, 32'h0000_0000, "R9 drained words");

        // Random traffic, R2-R10 checked every cycle by cycle().
        for (int n = 0; n < 3000; n++) begin
            idle();
            reg_cpu  = 3'($urandom_range(0, 7));
            reg_word = 2'($urandom_range(0, 3));
            reg_valid = ($urandom_range(0, 2) != 0);
            reg_write = reg_valid && ($urandom_range(0, 2) == 0);
            reg_clr   = ($urandom_range(0, 1) == 1);
            reg_wdata = $urandom() & $urandom() & $urandom();
            disp_valid = ($urandom_range(0, 3) == 0);
            disp_src = 3'($urandom_range(0, 7));
            disp_sgi = 4'($urandom_range(0, 15));
            disp_targets = 8'($urandom() & $urandom());
            dlv_req = ($urandom_range(0, 1) == 1);
            dlv_cpu = 3'($urandom_range(0, 7));
            dlv_sgi = 4'($urandom_range(0, 15));
            offer_accept = ($urandom_range(0, 2) != 0);
            cycle();
        end
        idle();
        cycle();
        finish_run();
    end
endmodule